// File: doc/BRIEF.md
# SATA Port Command and Status Register Slice

This block holds the software-visible control state of one SATA host-controller port. A processor reaches it through a plain 32-bit register bus with a write strobe, a word offset and combinational read data. The block keeps two 64-bit base addresses, each stored as a low and a high word: one for the command list and one for the area that receives incoming frames. It also holds an interrupt status word, an error word and the port command word.

Software starts and stops the two port engines through enable bits in the command word. When an enable is written as 1, the block checks the matching base address at that moment. Only if the base passes does it set the matching running bit, which software cannot write. If the base fails, it sets a sticky error bit and leaves the running bit as it was. Writing an enable as 0 while its engine runs drops the running bit. Stopping the command-list engine gives a one-cycle release pulse, and a good command-list start gives a one-cycle restart pulse that tells the fetch logic to begin from an empty pointer. The top nibble of the command word is decoded into a link power-state request for the link layer.

Top module: `sata_port_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every offset (0 to 7) reads 0, and `clist_run`, `fis_run`, `clist_restart`, `clist_release` and `pm_req` are 0.
- R2: Offsets 0/1 (command-list base low/high) and 2/3 (receive base low/high) store the full written word and read it back unchanged. Such a write changes no running bit and no error bit; the base is checked only when an engine is started.
- R3: A write to the command word at offset 5 keeps the old value of every bit set in mask 32'h007dffe0 and takes the written value in every other bit. The running bits 15 and 14 fall inside the mask.
- R4: When bit 0 (start) of the command word is 1 after a write and the command-list base {hi,lo} is nonzero with its low 10 bits zero, bit 15 (command list running) is set. `clist_restart` is high for exactly the cycle after that write.
- R5: When bit 0 is 1 after a write and the command-list base fails that check, bit 15 is left unchanged, no restart pulse occurs, and error bit 0 (offset 6) is set.
- R6: When bit 0 is 0 after a write and bit 15 was set, bit 15 is cleared and `clist_release` is high for exactly the cycle after that write.
- R7: When bit 4 (receive enable) is 1 after a write, bit 14 (receive running) is set if the receive base is nonzero with its low 8 bits zero. Otherwise bit 14 is left unchanged and error bit 1 (offset 6) is set.
- R8: When bit 4 is 0 after a write and bit 14 was set, bit 14 is cleared.
- R9: Interrupt status (offset 4) sets each bit whose `irq_evt` input is 1 and clears each bit written as 1. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: Error bits at offset 6 stay set until a write of 1 to that bit position. Bits written as 0 are untouched.
- R11: `pm_req` decodes command bits 31:28: value 2 gives 1 (partial), value 6 gives 2 (slumber), any other value gives 0.
- R12: Offset 7 reads 0, and a write to it changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at `addr` |
| irq_evt | input | 32 | Per-bit interrupt event set inputs |
| clist_run | output | 1 | Command-list engine running (command bit 15) |
| fis_run | output | 1 | Receive engine running (command bit 14) |
| clist_restart | output | 1 | One-cycle pulse: reset the current-command pointer |
| clist_release | output | 1 | One-cycle pulse: command list released on stop |
| pm_req | output | 2 | Link power request: 0 none, 1 partial, 2 slumber |

## Verification
The bench sweeps a single set bit across all 64 positions of each base address, plus the all-zero base. This exposes an alignment check set at the wrong width and a design that treats a zero base as valid: such a design would either start on a misaligned base or refuse an aligned one. It walks a single bit across the command word and then applies a long run of pseudo-random words. A wrong read-only mask would let software force a running bit or would drop a writable bit. The restart and release pulses are compared against a model at each write, which catches pulses that last two cycles or fire on a failed start. A status bit that receives an event and a clear in the same cycle must stay set; a clear-first design would lose that interrupt.

// File: rtl/sata_pcr_pkg.sv
// Package: shared offsets, bit positions and codes for the port register slice.
// Assumes a 32-bit register bus with word offsets.
package sata_pcr_pkg;

    localparam int DW     = 32;
    localparam int REG_AW = 3;

    // Register word offsets
    localparam logic [REG_AW-1:0] OFS_CLB_LO = 3'd0;
    localparam logic [REG_AW-1:0] OFS_CLB_HI = 3'd1;
    localparam logic [REG_AW-1:0] OFS_RFB_LO = 3'd2;
    localparam logic [REG_AW-1:0] OFS_RFB_HI = 3'd3;
    localparam logic [REG_AW-1:0] OFS_ISTAT  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_CMD    = 3'd5;
    localparam logic [REG_AW-1:0] OFS_ERR    = 3'd6;

    // Number of base-address words held
    localparam int NUM_BASE_WORDS = 4;

    // Command word bit positions
    localparam int CMD_START  = 0;
    localparam int CMD_RX_EN  = 4;
    localparam int CMD_RX_RUN = 14;
    localparam int CMD_CL_RUN = 15;
    localparam int CMD_PM_LSB = 28;
    localparam int PM_W       = 4;

    // Bits of the command word that software writes cannot change
    localparam logic [DW-1:0] CMD_KEEP_MASK = 32'h007d_ffe0;

    // Error word bit positions
    localparam int ERR_W      = 2;
    localparam int ERR_CL_BIT = 0;
    localparam int ERR_RX_BIT = 1;

    // Link power request codes
    typedef enum logic [1:0] {
        PM_NONE    = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_SLUMBER = 2'd2
    } pm_req_e;

    localparam logic [PM_W-1:0] PM_FIELD_PARTIAL = 4'h2;
    localparam logic [PM_W-1:0] PM_FIELD_SLUMBER = 4'h6;

endpackage

// File: rtl/base_window_check.sv
// Module: base_window_check
// Decides whether a 64-bit base, given as two 32-bit words, may be used
// for a region of 2**ALIGN_LOG2 bytes: it must be nonzero and aligned.
// Assumes ALIGN_LOG2 is between 1 and 31. Purely combinational.
module base_window_check #(
    parameter int ALIGN_LOG2 = 10
) (
    input  logic [31:0] base_lo,
    input  logic [31:0] base_hi,
    output logic        base_ok
);

    localparam int ALW = (ALIGN_LOG2 < 1) ? 1 : ALIGN_LOG2;

    logic nonzero;
    logic aligned;

    // Combine the zero test and the alignment test
    always_comb begin
        nonzero = (base_lo != 32'd0) || (base_hi != 32'd0);
        aligned = (base_lo[ALW-1:0] == '0);
        base_ok = nonzero && aligned;
    end

endmodule

// File: rtl/w1c_flags.sv
// Module: w1c_flags
// A bank of sticky flags: set by hardware, cleared by software writing 1.
// A set and a clear on the same bit in the same cycle leave the bit set.
// Assumes synchronous active-low reset.
module w1c_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags_q
);

    logic [W-1:0] clr_eff;

    // Qualify the clear mask with its write strobe
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Update the flags, with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_eff) | set_i;
        end
    end

endmodule

// File: rtl/engine_handshake.sv
// Module: engine_handshake
// Works out the next running state of one port engine from the enable bit
// the command word would hold after a write. Starting succeeds only on a
// usable base; a failed start keeps the old running state. Combinational;
// the caller qualifies the outputs with its write strobe.
module engine_handshake (
    input  logic en_next,
    input  logic run_old,
    input  logic base_ok,
    output logic run_next,
    output logic go,
    output logic fail,
    output logic stop
);

    // Decide start, refusal or stop for this engine
    always_comb begin
        run_next = run_old;
        go       = 1'b0;
        fail     = 1'b0;
        stop     = 1'b0;
        if (en_next) begin
            if (base_ok) begin
                run_next = 1'b1;
                go       = 1'b1;
            end else begin
                fail     = 1'b1;
            end
        end else if (run_old) begin
            run_next = 1'b0;
            stop     = 1'b1;
        end
    end

endmodule

// File: rtl/sata_port_ctl_regs.sv
// Module: sata_port_ctl_regs
// Register slice of one SATA port: two 64-bit base addresses, an interrupt
// status word, a sticky error word and the command word with its engine
// start handshakes. Reads are combinational from addr. Writes take effect at
// the clock edge where wr_en is high. Assumes synchronous active-low reset.
module sata_port_ctl_regs
    import sata_pcr_pkg::*;
#(
    parameter int CL_ALIGN_LOG2 = 10,
    parameter int RX_ALIGN_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [DW-1:0]     irq_evt,
    output logic              clist_run,
    output logic              fis_run,
    output logic              clist_restart,
    output logic              clist_release,
    output logic [1:0]        pm_req
);

    localparam int NUM_ENG = 2;
    localparam int ENG_CL  = 0;
    localparam int ENG_RX  = 1;

    logic [DW-1:0] base_q [NUM_BASE_WORDS];
    logic [DW-1:0] cmd_q;
    logic [DW-1:0] cmd_merged;
    logic [DW-1:0] cmd_next;
    logic [DW-1:0] istat_q;
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_set;
    logic          wr_cmd;
    logic          wr_istat;
    logic          wr_err;
    logic          restart_q;
    logic          release_q;

    logic [NUM_ENG-1:0] eng_en;
    logic [NUM_ENG-1:0] eng_run_old;
    logic [NUM_ENG-1:0] eng_ok;
    logic [NUM_ENG-1:0] eng_run_next;
    logic [NUM_ENG-1:0] eng_go;
    logic [NUM_ENG-1:0] eng_fail;
    logic [NUM_ENG-1:0] eng_stop;

    // Decode write strobes per register
    always_comb begin
        wr_cmd   = wr_en && (addr == OFS_CMD);
        wr_istat = wr_en && (addr == OFS_ISTAT);
        wr_err   = wr_en && (addr == OFS_ERR);
    end

    // Store the base-address words; no checking on write
    for (genvar g = 0; g < NUM_BASE_WORDS; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else if (wr_en && (addr == REG_AW'(g))) begin
                base_q[g] <= wdata;
            end
        end
    end

    // Check both bases against their region sizes
    base_window_check #(.ALIGN_LOG2(CL_ALIGN_LOG2)) u_cl_chk (
        .base_lo (base_q[OFS_CLB_LO]),
        .base_hi (base_q[OFS_CLB_HI]),
        .base_ok (eng_ok[ENG_CL])
    );

    base_window_check #(.ALIGN_LOG2(RX_ALIGN_LOG2)) u_rx_chk (
        .base_lo (base_q[OFS_RFB_LO]),
        .base_hi (base_q[OFS_RFB_HI]),
        .base_ok (eng_ok[ENG_RX])
    );

    // Merge the write into the command word under the keep mask
    always_comb begin
        cmd_merged = (cmd_q & CMD_KEEP_MASK) | (wdata & ~CMD_KEEP_MASK);
        eng_en[ENG_CL]      = cmd_merged[CMD_START];
        eng_en[ENG_RX]      = cmd_merged[CMD_RX_EN];
        eng_run_old[ENG_CL] = cmd_q[CMD_CL_RUN];
        eng_run_old[ENG_RX] = cmd_q[CMD_RX_RUN];
    end

    // One handshake per engine
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        engine_handshake u_hs (
            .en_next  (eng_en[e]),
            .run_old  (eng_run_old[e]),
            .base_ok  (eng_ok[e]),
            .run_next (eng_run_next[e]),
            .go       (eng_go[e]),
            .fail     (eng_fail[e]),
            .stop     (eng_stop[e])
        );
    end

    // Form the next command word with the engine-owned running bits
    always_comb begin
        cmd_next             = cmd_merged;
        cmd_next[CMD_CL_RUN] = eng_run_next[ENG_CL];
        cmd_next[CMD_RX_RUN] = eng_run_next[ENG_RX];
    end

    // Hold the command word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= cmd_next;
        end
    end

    // Register the one-cycle restart and release pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            release_q <= 1'b0;
        end else begin
            restart_q <= wr_cmd && eng_go[ENG_CL];
            release_q <= wr_cmd && eng_stop[ENG_CL];
        end
    end

    // Route refused starts into the error flag bits
    always_comb begin
        err_set             = '0;
        err_set[ERR_CL_BIT] = wr_cmd && eng_fail[ENG_CL];
        err_set[ERR_RX_BIT] = wr_cmd && eng_fail[ENG_RX];
    end

    w1c_flags #(.W(DW)) u_istat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (irq_evt),
        .clr_we   (wr_istat),
        .clr_mask (wdata),
        .flags_q  (istat_q)
    );

    w1c_flags #(.W(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_set),
        .clr_we   (wr_err),
        .clr_mask (wdata[ERR_W-1:0]),
        .flags_q  (err_q)
    );

    // Select read data by offset
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CLB_LO: rdata = base_q[OFS_CLB_LO];
            OFS_CLB_HI: rdata = base_q[OFS_CLB_HI];
            OFS_RFB_LO: rdata = base_q[OFS_RFB_LO];
            OFS_RFB_HI: rdata = base_q[OFS_RFB_HI];
            OFS_ISTAT:  rdata = istat_q;
            OFS_CMD:    rdata = cmd_q;
            OFS_ERR:    rdata = {{(DW-ERR_W){1'b0}}, err_q};
            default:    rdata = '0;
        endcase
    end

    // Decode the link power request field
    always_comb begin
        case (cmd_q[CMD_PM_LSB +: PM_W])
            PM_FIELD_PARTIAL: pm_req = PM_PARTIAL;
            PM_FIELD_SLUMBER: pm_req = PM_SLUMBER;
            default:          pm_req = PM_NONE;
        endcase
    end

    // Drive the status outputs
    always_comb begin
        clist_run     = cmd_q[CMD_CL_RUN];
        fis_run       = cmd_q[CMD_RX_RUN];
        clist_restart = restart_q;
        clist_release = release_q;
    end

endmodule

// File: rtl/sata_port_ctl_regs_chk.sv
// Module: sata_port_ctl_regs_chk
// Temporal checks on the ports of sata_port_ctl_regs, bound to every instance.
// Assumes reset is held for at least two clock cycles at start-up.
module sata_port_ctl_regs_chk
    import sata_pcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic              clist_run,
    input logic              fis_run,
    input logic              clist_restart,
    input logic              clist_release,
    input logic [1:0]        pm_req
);

    // R4: command list runs only after a command write carrying start
    p_cl_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clist_run) |-> $past(wr_en && (addr == OFS_CMD) && wdata[CMD_START]));

    // R4: a restart pulse always comes with a running command list
    p_restart_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clist_restart |-> clist_run);

    // R6: a release pulse follows a running list that has just stopped
    p_release_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clist_release |-> (!clist_run && $past(clist_run)));

    // R7: receive engine runs only after a command write carrying its enable
    p_rx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fis_run) |-> $past(wr_en && (addr == OFS_CMD) && wdata[CMD_RX_EN]));

    // R2: base-word writes leave both running bits alone
    p_base_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (addr < OFS_ISTAT)) |->
            (clist_run == $past(clist_run)) && (fis_run == $past(fis_run)));

    // R11: the power request never takes the unused code
    p_pm_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req != 2'b11);

    // R6: restart and release never fire together
    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clist_restart && clist_release));

endmodule

bind sata_port_ctl_regs sata_port_ctl_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .clist_run     (clist_run),
    .fis_run       (fis_run),
    .clist_restart (clist_restart),
    .clist_release (clist_release),
    .pm_req        (pm_req)
);

// File: tb/sata_port_ctl_regs_test.sv
// Bench for sata_port_ctl_regs: sweeps base addresses and command words and
// compares against a model built from the requirements.
module sata_port_ctl_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [31:0] irq_evt = 32'd0;
    logic        clist_run, fis_run, clist_restart, clist_release;
    logic [1:0]  pm_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [31:0] m_base [4];
    logic [31:0] m_cmd   = 32'd0;
    logic [1:0]  m_err   = 2'd0;
    logic [31:0] m_istat = 32'd0;

    localparam logic [31:0] KEEP = 32'h007d_ffe0;

    always #10 clk = ~clk;

    sata_port_ctl_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_evt(irq_evt), .clist_run(clist_run), .fis_run(fis_run),
        .clist_restart(clist_restart), .clist_release(clist_release), .pm_req(pm_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic bit usable(input logic [31:0] lo, input logic [31:0] hi, input int al);
        return ({hi, lo} != 64'd0) && ((lo % (32'd1 << al)) == 32'd0);
    endfunction

    task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    // Model a command write (R3 to R8) and check every visible effect
    task automatic cmd_write(input logic [31:0] w, input string req);
        logic [31:0] n;
        bit rs, rl;
        n  = (m_cmd & KEEP) | (w & ~KEEP);
        rs = 1'b0; rl = 1'b0;
        if (n[0]) begin
            if (usable(m_base[0], m_base[1], 10)) begin n[15] = 1'b1; rs = 1'b1; end
            else m_err[0] = 1'b1;
        end else if (n[15]) begin
            n[15] = 1'b0; rl = 1'b1;
        end
        if (n[4]) begin
            if (usable(m_base[2], m_base[3], 8)) n[14] = 1'b1;
            else m_err[1] = 1'b1;
        end else if (n[14]) begin
            n[14] = 1'b0;
        end
        m_cmd = n;
        bus_write(3'd5, w);
        chk({req, " R4 restart"}, {31'd0, clist_restart}, {31'd0, rs});
        chk({req, " R6 release"}, {31'd0, clist_release}, {31'd0, rl});
        chk({req, " R4 clist_run"}, {31'd0, clist_run}, {31'd0, m_cmd[15]});
        chk({req, " R7 fis_run"}, {31'd0, fis_run}, {31'd0, m_cmd[14]});
        read_chk({req, " R3 cmd"}, 3'd5, m_cmd);
        read_chk({req, " R5 err"}, 3'd6, {30'd0, m_err});
        @(negedge clk);
        chk({req, " R4 pulse one cycle"}, {30'd0, clist_restart, clist_release}, 32'd0);
    endtask

    task automatic base_write(input int idx, input logic [31:0] d);
        m_base[idx] = d;
        bus_write(3'(idx), d);
    endtask

    task automatic err_clear();
        bus_write(3'd6, 32'h3);
        m_err = 2'd0;
        read_chk("R10 err cleared", 3'd6, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) m_base[i] = 32'd0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) read_chk("R1 reset read", 3'(a), 32'd0);
        chk("R1 reset outputs", {27'd0, clist_run, fis_run, clist_restart, clist_release, pm_req != 2'd0},
            32'd0);

        // R2: base words store exactly and check nothing
        for (int i = 0; i < 4; i++) begin
            base_write(i, 32'hA5A5_0001 + 32'(i) * 32'h1111_1111);
            chk("R2 no run on base write", {30'd0, clist_run, fis_run}, 32'd0);
        end
        for (int i = 0; i < 4; i++) read_chk("R2 base readback", 3'(i), m_base[i]);
        read_chk("R2 err untouched", 3'd6, 32'd0);

        // R4/R5/R6: sweep one set bit over the command-list base, plus zero
        base_write(2, 32'd0); base_write(3, 32'd0);
        for (int b = -1; b < 64; b++) begin
            logic [63:0] base;
            base = (b < 0) ? 64'd0 : (64'd1 << b);
            base_write(0, base[31:0]);
            base_write(1, base[63:32]);
            cmd_write(32'h0000_0001, "R4/R5 cl start");
            cmd_write(32'h0000_0000, "R6 cl stop");
            if (m_err != 2'd0) err_clear();
        end

        // R7/R8: sweep one set bit over the receive base, plus zero
        base_write(0, 32'd0); base_write(1, 32'd0);
        for (int b = -1; b < 64; b++) begin
            logic [63:0] base;
            base = (b < 0) ? 64'd0 : (64'd1 << b);
            base_write(2, base[31:0]);
            base_write(3, base[63:32]);
            cmd_write(32'h0000_0010, "R7 rx start");
            cmd_write(32'h0000_0000, "R8 rx stop");
            if (m_err != 2'd0) err_clear();
        end

        // R3: walking one over the command word, then pseudo-random words
        base_write(0, 32'h0000_0400); base_write(1, 32'd0);
        base_write(2, 32'h0000_0100); base_write(3, 32'd0);
        for (int i = 0; i < 32; i++) cmd_write(32'd1 << i, "R3 walk");
        cmd_write(32'hFFFF_FFFF, "R3 all ones");
        cmd_write(32'h0000_0000, "R3 all zero");
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            cmd_write(lfsr, "R3 random");
        end
        cmd_write(32'h0000_0000, "R3 park");

        // R5: failed start while stopped keeps bit 15 clear; error sticky (R10)
        base_write(0, 32'h0000_0200);
        cmd_write(32'h0000_0001, "R5 misaligned");
        base_write(2, 32'h0000_0080);
        cmd_write(32'h0000_0011, "R7 misaligned");
        base_write(0, 32'h0000_0400);
        read_chk("R10 sticky after other writes", 3'd6, {30'd0, m_err});
        bus_write(3'd6, 32'h2);
        m_err[1] = 1'b0;
        read_chk("R10 partial clear", 3'd6, {30'd0, m_err});
        err_clear();
        cmd_write(32'h0000_0000, "R6 final stop");

        // R9: interrupt events, write-one-to-clear, set beats clear
        @(negedge clk);
        irq_evt = 32'h8000_0F01;
        @(negedge clk);
        irq_evt = 32'd0;
        m_istat = 32'h8000_0F01;
        read_chk("R9 events set", 3'd4, m_istat);
        bus_write(3'd4, 32'h0000_0300);
        m_istat &= ~32'h0000_0300;
        read_chk("R9 w1c", 3'd4, m_istat);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 32'h8000_0001; irq_evt = 32'h8000_0000;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0; irq_evt = 32'd0;
        m_istat = (m_istat & ~32'h8000_0001) | 32'h8000_0000;
        read_chk("R9 set wins", 3'd4, m_istat);

        // R11: sweep the power request field
        for (int v = 0; v < 16; v++) begin
            logic [1:0] e;
            e = (v == 2) ? 2'd1 : (v == 6) ? 2'd2 : 2'd0;
            cmd_write(32'(v) << 28, "R11 pm field");
            chk("R11 pm_req", {30'd0, pm_req}, {30'd0, e});
        end

        // R12: offset 7 is inert
        bus_write(3'd7, 32'hFFFF_FFFF);
        read_chk("R12 offset 7 reads zero", 3'd7, 32'd0);
        for (int a = 0; a < 4; a++) read_chk("R12 base unchanged", 3'(a), m_base[a]);
        read_chk("R12 istat unchanged", 3'd4, m_istat);
        read_chk("R12 cmd unchanged", 3'd5, m_cmd);
        bus_read(3'd6, d);
        chk("R12 err unchanged", d, {30'd0, m_err});

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule